// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block drives a parallel LCD panel. It produces line sync, frame sync and data-enable from a set of registers, and it picks the colour driven on the pixel bus for every clock. A horizontal counter wraps once per line. A separate frame counter runs over every pixel clock of the frame, so every vertical edge (frame sync end, first and last displayed row, window top and bottom) is an absolute pixel-clock count and can fall anywhere inside a line. Software adds any skew to those counts before it writes them.

Inside the display area, an optional active window takes pixels from an upstream stream through a valid/ready pair. Display pixels outside that window get a border colour. If the stream is not ready when a window pixel is due, the block switches to an underflow colour. It can return to stream data at the next frame, or it can stay on the underflow colour until it is stopped. Software programs the registers through a word-indexed write port.

Top module: `lcd_timing_gen`

## Requirements
- R1: Register index 0 bit 0 runs the generator when 1 and stops it when 0. While the generator is stopped, both counters are held at 0, `pix_ready`, `frame_start` and `lcd_rgb` are 0, and each sync and enable output sits at its inactive level. This is also the state after reset.
- R2: Index 1 holds the line length L in bits [27:16] and the hsync width in bits [11:0]. The horizontal position h counts 0..L-1 and then wraps. Hsync is active while h is below the hsync width.
- R3: Index 2 holds the frame length F in pixel clocks. The frame position f counts 0..F-1 regardless of h and then wraps. Index 3 holds the vsync width in pixel clocks, and vsync is active while f is below it.
- R4: The display area is the set of positions where h lies between index 4 bits [11:0] and bits [27:16], and f lies between index 5 and index 6, all bounds inclusive. `lcd_de` is active exactly at those positions.
- R5: Index 7 bit 31 turns on the horizontal window limit, with start in bits [11:0] and end in bits [27:16]. Index 8 bit 31 turns on the vertical limit, with the start count in its low bits, and index 9 holds the end count. With a limit off, the whole display range on that axis is inside the window.
- R6: A display pixel outside the window carries the border colour (index 10). A pixel outside the display area carries 0.
- R7: At a window position, `pix_ready` is 1 during the counter cycle. The `pix_data` sampled at that edge appears on `lcd_rgb` one clock later.
- R8: If a window position finds `pix_valid` low, that pixel and every later display pixel carry the underflow colour (index 11, low bits) and `pix_ready` stays 0. When index 11 bit 31 is 1, this state clears when f wraps to 0. When bit 31 is 0, the state holds until the generator is stopped.
- R9: Index 12 sets the output polarities: bit 0 for hsync, bit 1 for vsync, bit 2 for data-enable. A 1 makes that output active-low.
- R10: `frame_start` is a one-clock pulse for position f = 0 of every frame, including the first frame after a start.
- R11: Sync, enable, colour and `frame_start` are registered. Each one shows the counter position of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word index |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Upstream pixel available |
| pix_data | input | PIX_W | Upstream pixel colour |
| pix_ready | output | 1 | Pixel consumed at this edge |
| lcd_hsync | output | 1 | Line sync |
| lcd_vsync | output | 1 | Frame sync |
| lcd_de | output | 1 | Data enable |
| lcd_rgb | output | PIX_W | Pixel bus |
| frame_start | output | 1 | Frame start pulse |

## Verification
The hardest state to reach is underflow. It only happens when `pix_valid` drops at a window position, and its two exits, recovery at the frame wrap or a hold until stop, only show up a frame later. The bench withholds one pixel at a known counter position inside the display area. It then sweeps two whole frames under each recovery setting. Next it stops and restarts the generator and confirms that the stuck state has cleared. Each cycle of each sweep is compared against an arithmetic model of the positions.

// File: rtl/lcdtg_pkg.sv
// Shared constants for the LCD timing generator: register word indices
// and control bit positions. Assumes 32-bit register writes.
package lcdtg_pkg;
    localparam int REG_ENABLE     = 0;
    localparam int REG_LINE       = 1;
    localparam int REG_FRAME      = 2;
    localparam int REG_VSYNC_W    = 3;
    localparam int REG_DISP_H     = 4;
    localparam int REG_DISP_V0    = 5;
    localparam int REG_DISP_V1    = 6;
    localparam int REG_WIN_H      = 7;
    localparam int REG_WIN_V0     = 8;
    localparam int REG_WIN_V1     = 9;
    localparam int REG_BORDER     = 10;
    localparam int REG_UNDERFLOW  = 11;
    localparam int REG_POLARITY   = 12;
    localparam int CTRL_BIT       = 31;  // window enable / recovery bit
    localparam int HI_FIELD_LSB   = 16;  // upper packed coordinate field
endpackage

// File: rtl/lcdtg_regs.sv
// Register file of the timing generator. It decodes word-indexed writes
// into trimmed configuration fields. Assumes H_W <= 15 and PIX_W <= 31,
// so packed fields never overlap a control bit.
module lcdtg_regs
    import lcdtg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int H_W    = 12,
    parameter int F_W    = 24,
    parameter int PIX_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]      wdata,
    output logic             run,
    output logic [H_W-1:0]   line_len,
    output logic [H_W-1:0]   hs_w,
    output logic [F_W-1:0]   frame_len,
    output logic [F_W-1:0]   vs_w,
    output logic [H_W-1:0]   dh_s,
    output logic [H_W-1:0]   dh_e,
    output logic [F_W-1:0]   dv_s,
    output logic [F_W-1:0]   dv_e,
    output logic             wx_en,
    output logic [H_W-1:0]   wh_s,
    output logic [H_W-1:0]   wh_e,
    output logic             wy_en,
    output logic [F_W-1:0]   wv_s,
    output logic [F_W-1:0]   wv_e,
    output logic [PIX_W-1:0] border,
    output logic [PIX_W-1:0] uf_colour,
    output logic             recover,
    output logic [2:0]       pol
);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(REG_ENABLE);
    localparam logic [ADDR_W-1:0] A_LN  = ADDR_W'(REG_LINE);
    localparam logic [ADDR_W-1:0] A_FR  = ADDR_W'(REG_FRAME);
    localparam logic [ADDR_W-1:0] A_VW  = ADDR_W'(REG_VSYNC_W);
    localparam logic [ADDR_W-1:0] A_DH  = ADDR_W'(REG_DISP_H);
    localparam logic [ADDR_W-1:0] A_DV0 = ADDR_W'(REG_DISP_V0);
    localparam logic [ADDR_W-1:0] A_DV1 = ADDR_W'(REG_DISP_V1);
    localparam logic [ADDR_W-1:0] A_WH  = ADDR_W'(REG_WIN_H);
    localparam logic [ADDR_W-1:0] A_WV0 = ADDR_W'(REG_WIN_V0);
    localparam logic [ADDR_W-1:0] A_WV1 = ADDR_W'(REG_WIN_V1);
    localparam logic [ADDR_W-1:0] A_BD  = ADDR_W'(REG_BORDER);
    localparam logic [ADDR_W-1:0] A_UF  = ADDR_W'(REG_UNDERFLOW);
    localparam logic [ADDR_W-1:0] A_PL  = ADDR_W'(REG_POLARITY);
    localparam int HL = HI_FIELD_LSB;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Capture writes into the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; line_len <= '0; hs_w <= '0; frame_len <= '0;
            vs_w <= '0; dh_s <= '0; dh_e <= '0; dv_s <= '0; dv_e <= '0;
            wx_en <= 1'b0; wh_s <= '0; wh_e <= '0; wy_en <= 1'b0;
            wv_s <= '0; wv_e <= '0; border <= '0; uf_colour <= '0;
            recover <= 1'b0; pol <= '0;
        end else if (we) begin
            case (addr)
                A_EN:  run <= wdata[0];
                A_LN:  begin line_len <= wdata[HL +: H_W]; hs_w <= wdata[H_W-1:0]; end
                A_FR:  frame_len <= wdata[F_W-1:0];
                A_VW:  vs_w <= wdata[F_W-1:0];
                A_DH:  begin dh_e <= wdata[HL +: H_W]; dh_s <= wdata[H_W-1:0]; end
                A_DV0: dv_s <= wdata[F_W-1:0];
                A_DV1: dv_e <= wdata[F_W-1:0];
                A_WH:  begin
                           wx_en <= wdata[CTRL_BIT];
                           wh_e  <= wdata[HL +: H_W];
                           wh_s  <= wdata[H_W-1:0];
                       end
                A_WV0: begin wy_en <= wdata[CTRL_BIT]; wv_s <= wdata[F_W-1:0]; end
                A_WV1: wv_e <= wdata[F_W-1:0];
                A_BD:  border <= wdata[PIX_W-1:0];
                A_UF:  begin recover <= wdata[CTRL_BIT]; uf_colour <= wdata[PIX_W-1:0]; end
                A_PL:  pol <= wdata[2:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lcdtg_counters.sv
// Line and frame position counters. The line counter wraps at line_len and
// the frame counter wraps at frame_len, independently of each other. Both
// are held at zero while stopped. A length of 0 behaves as a length of 1.
module lcdtg_counters #(
    parameter int H_W = 12,
    parameter int F_W = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [H_W-1:0] line_len,
    input  logic [F_W-1:0] frame_len,
    output logic [H_W-1:0] h_cnt,
    output logic [F_W-1:0] f_cnt,
    output logic           f_last
);
    logic h_last;

    // Detect the final position of a line and of a frame.
    always_comb begin
        h_last = ({1'b0, h_cnt} + 1'b1) >= {1'b0, line_len};
        f_last = ({1'b0, f_cnt} + 1'b1) >= {1'b0, frame_len};
    end

    // Advance both counters while running, clear them while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            h_cnt <= '0;
            f_cnt <= '0;
        end else begin
            h_cnt <= h_last ? '0 : h_cnt + 1'b1;
            f_cnt <= f_last ? '0 : f_cnt + 1'b1;
        end
    end

    p_h_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_last) |=> (h_cnt == '0));
    p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !h_last) |=> (h_cnt == $past(h_cnt) + 1'b1));
    p_f_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !f_last) |=> (f_cnt == $past(f_cnt) + 1'b1));
    p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (h_cnt == '0 && f_cnt == '0));
endmodule

// File: rtl/lcdtg_pixel_path.sv
// Window decode, underflow tracking and registered panel outputs. It
// assumes the counters hold the current position and that every bound
// is inclusive. Outputs lag the counter position by one clock.
module lcdtg_pixel_path #(
    parameter int H_W   = 12,
    parameter int F_W   = 24,
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [H_W-1:0]   h_cnt,
    input  logic [F_W-1:0]   f_cnt,
    input  logic             f_last,
    input  logic [H_W-1:0]   hs_w,
    input  logic [F_W-1:0]   vs_w,
    input  logic [H_W-1:0]   dh_s,
    input  logic [H_W-1:0]   dh_e,
    input  logic [F_W-1:0]   dv_s,
    input  logic [F_W-1:0]   dv_e,
    input  logic             wx_en,
    input  logic [H_W-1:0]   wh_s,
    input  logic [H_W-1:0]   wh_e,
    input  logic             wy_en,
    input  logic [F_W-1:0]   wv_s,
    input  logic [F_W-1:0]   wv_e,
    input  logic [PIX_W-1:0] border,
    input  logic [PIX_W-1:0] uf_colour,
    input  logic             recover,
    input  logic [2:0]       pol,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    output logic             pix_ready,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [PIX_W-1:0] rgb,
    output logic             frame_start
);
    logic hs_act, vs_act, in_disp, in_win, starve, uf_q;

    // Classify the current position against every programmed region.
    always_comb begin
        hs_act  = h_cnt < hs_w;
        vs_act  = f_cnt < vs_w;
        in_disp = (h_cnt >= dh_s) && (h_cnt <= dh_e) &&
                  (f_cnt >= dv_s) && (f_cnt <= dv_e);
        in_win  = in_disp &&
                  (!wx_en || ((h_cnt >= wh_s) && (h_cnt <= wh_e))) &&
                  (!wy_en || ((f_cnt >= wv_s) && (f_cnt <= wv_e)));
        starve    = run && in_win && !pix_valid;
        pix_ready = run && in_win && !uf_q;
    end

    // Track the underflow state: set on starvation, cleared by stop or recovery.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)         uf_q <= 1'b0;
        else if (f_last && recover) uf_q <= 1'b0;
        else if (starve)            uf_q <= 1'b1;
    end

    // Register the panel outputs for the current position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync <= 1'b0; vsync <= 1'b0; de <= 1'b0;
            rgb <= '0; frame_start <= 1'b0;
        end else if (!run) begin
            hsync <= pol[0]; vsync <= pol[1]; de <= pol[2];
            rgb <= '0; frame_start <= 1'b0;
        end else begin
            hsync       <= hs_act ^ pol[0];
            vsync       <= vs_act ^ pol[1];
            de          <= in_disp ^ pol[2];
            frame_start <= (f_cnt == '0);
            if (!in_disp)               rgb <= '0;
            else if (starve || uf_q)    rgb <= uf_colour;
            else if (in_win)            rgb <= pix_data;
            else                        rgb <= border;
        end
    end

    p_ready_in_display_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |=> (de != $past(pol[2])));
    p_ready_takes_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && pix_valid) |=> (rgb == $past(pix_data)));
    p_uf_colour_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && uf_q && in_disp) |=> (rgb == $past(uf_colour)));
    p_stopped_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (rgb == '0 && !frame_start && !pix_ready));
endmodule

// File: rtl/lcd_timing_gen.sv
// Top of the LCD panel timing generator: register file, position
// counters and pixel path. Assumes the pixel clock is the only clock and
// that software writes consistent bounds (start <= end, inside the frame).
module lcd_timing_gen #(
    parameter int ADDR_W = 4,
    parameter int H_W    = 12,
    parameter int F_W    = 24,
    parameter int PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              pix_ready,
    output logic              lcd_hsync,
    output logic              lcd_vsync,
    output logic              lcd_de,
    output logic [PIX_W-1:0]  lcd_rgb,
    output logic              frame_start
);
    logic             run, wx_en, wy_en, recover, f_last;
    logic [H_W-1:0]   line_len, hs_w, dh_s, dh_e, wh_s, wh_e, h_cnt;
    logic [F_W-1:0]   frame_len, vs_w, dv_s, dv_e, wv_s, wv_e, f_cnt;
    logic [PIX_W-1:0] border, uf_colour;
    logic [2:0]       pol;

    lcdtg_regs #(.ADDR_W(ADDR_W), .H_W(H_W), .F_W(F_W), .PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .run(run), .line_len(line_len), .hs_w(hs_w), .frame_len(frame_len),
        .vs_w(vs_w), .dh_s(dh_s), .dh_e(dh_e), .dv_s(dv_s), .dv_e(dv_e),
        .wx_en(wx_en), .wh_s(wh_s), .wh_e(wh_e), .wy_en(wy_en), .wv_s(wv_s),
        .wv_e(wv_e), .border(border), .uf_colour(uf_colour), .recover(recover),
        .pol(pol)
    );

    lcdtg_counters #(.H_W(H_W), .F_W(F_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .line_len(line_len),
        .frame_len(frame_len), .h_cnt(h_cnt), .f_cnt(f_cnt), .f_last(f_last)
    );

    lcdtg_pixel_path #(.H_W(H_W), .F_W(F_W), .PIX_W(PIX_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .run(run), .h_cnt(h_cnt), .f_cnt(f_cnt),
        .f_last(f_last), .hs_w(hs_w), .vs_w(vs_w), .dh_s(dh_s), .dh_e(dh_e),
        .dv_s(dv_s), .dv_e(dv_e), .wx_en(wx_en), .wh_s(wh_s), .wh_e(wh_e),
        .wy_en(wy_en), .wv_s(wv_s), .wv_e(wv_e), .border(border),
        .uf_colour(uf_colour), .recover(recover), .pol(pol),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .hsync(lcd_hsync), .vsync(lcd_vsync), .de(lcd_de), .rgb(lcd_rgb),
        .frame_start(frame_start)
    );
endmodule

// File: tb/sim_lcd_timing_gen.sv
// Bench: small panel, whole-frame sweeps compared against an arithmetic model.
module sim_lcd_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 24;
    // Panel: hsync 2, hbp 2, width 6, hfp 2; vsync 1, vbp 1, height 4, vfp 1; skew 3
    localparam int L   = 12;
    localparam int F   = 7 * L;
    localparam int VSW = 1 * L;
    localparam int HSW = 2;
    localparam int DHS = 4;
    localparam int DHE = L - 2 - 1;
    localparam int DVS = 2 * L + 3;
    localparam int DVE = F - L + 3 - 1;
    localparam int STARVE_C = 30;
    localparam logic [PW-1:0] BORDER = 24'h00B0B0;
    localparam logic [PW-1:0] UFC    = 24'hFF0011;

    logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, pix_valid = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [PW-1:0] pix_data = '0;
    logic pix_ready, lcd_hsync, lcd_vsync, lcd_de, frame_start;
    logic [PW-1:0] lcd_rgb;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    int xen, xs, xe, yen, ys, ye, rec, starve_on, polv;
    int exp_uf;
    int p_hs, p_vs, p_de, p_rgb, p_fs;
    string p_tag;

    lcd_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_de(lcd_de), .lcd_rgb(lcd_rgb), .frame_start(frame_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string sig, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, sig, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_idle_prev();
        p_hs = polv & 1; p_vs = (polv >> 1) & 1; p_de = (polv >> 2) & 1;
        p_rgb = 0; p_fs = 0; p_tag = "R1";
    endtask

    // One cycle: check last position's outputs, evaluate the current one.
    task automatic step(int c);
        int h, f, hs, vs, disp, win, starve;
        chk("R2/R9", "hsync", int'(lcd_hsync), p_hs);
        chk("R3/R9", "vsync", int'(lcd_vsync), p_vs);
        chk("R4/R9", "de", int'(lcd_de), p_de);
        chk("R10", "frame_start", int'(frame_start), p_fs);
        chk(p_tag, "rgb", int'(lcd_rgb), p_rgb);
        h = c % L; f = c % F;
        hs = (h < HSW); vs = (f < VSW);
        disp = (h >= DHS && h <= DHE && f >= DVS && f <= DVE);
        win = disp && (xen == 0 || (h >= xs && h <= xe)) &&
                      (yen == 0 || (f >= ys && f <= ye));
        starve = win && starve_on != 0 && c == STARVE_C;
        pix_valid = !starve;
        pix_data = 24'h5A0000 + PW'(c);
        chk("R7/R8", "pix_ready", int'(pix_ready), (win && exp_uf == 0) ? 1 : 0);
        p_hs = hs ^ (polv & 1);
        p_vs = vs ^ ((polv >> 1) & 1);
        p_de = disp ^ ((polv >> 2) & 1);
        p_fs = (f == 0);
        if (!disp) begin p_rgb = 0; p_tag = "R6"; end
        else if (starve || exp_uf != 0) begin p_rgb = int'(UFC); p_tag = "R8"; end
        else if (win) begin p_rgb = int'(pix_data); p_tag = "R7"; end
        else begin p_rgb = int'(BORDER); p_tag = "R6/R5"; end
        if (f == F - 1 && rec != 0) exp_uf = 0;
        else if (starve) exp_uf = 1;
        @(negedge clk);
    endtask

    task automatic scenario(int wx, int wy, int pl, int r, int st, int ncyc);
        xen = wx; xs = DHS + 1; xe = DHS + 3;
        yen = wy; ys = DVS + L; ye = DVS + 3 * L - 1;
        polv = pl; rec = r; starve_on = st; exp_uf = 0;
        wr(0, 32'd0);
        wr(7, {1'(wx), 3'b0, 12'(xe), 4'b0, 12'(xs)});
        wr(8, {1'(wy), 7'b0, 24'(ys)});
        wr(9, 32'(ye));
        wr(11, {1'(r), 7'b0, UFC});
        wr(12, 32'(pl));
        wr(0, 32'd1);
        set_idle_prev();
        for (int c = 0; c < ncyc; c++) step(c);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        polv = 0; pix_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "hsync", int'(lcd_hsync), 0);
        chk("R1", "vsync", int'(lcd_vsync), 0);
        chk("R1", "de", int'(lcd_de), 0);
        chk("R1", "rgb", int'(lcd_rgb), 0);
        chk("R1", "frame_start", int'(frame_start), 0);
        chk("R1", "pix_ready", int'(pix_ready), 0);
        wr(1, {4'b0, 12'(L), 4'b0, 12'(HSW)});
        wr(2, 32'(F));
        wr(3, 32'(VSW));
        wr(4, {4'b0, 12'(DHE), 4'b0, 12'(DHS)});
        wr(5, 32'(DVS));
        wr(6, 32'(DVE));
        wr(10, {8'b0, BORDER});
        // R2 R3 R4 R10 R11: full window, active-high, one frame and a bit
        scenario(0, 0, 0, 0, 0, F + 4);
        // R5 R6 R9: sub-window on both axes, all outputs active-low
        scenario(1, 1, 7, 0, 0, 2 * F + 2);
        // R8 with recovery: one starved pixel, clears at the frame wrap
        scenario(0, 0, 0, 1, 1, 2 * F + 2);
        // R8 without recovery: stays on the underflow colour
        scenario(0, 0, 2, 0, 1, 2 * F + 2);
        // R1: stop, idle levels under polarity 2, then restart clears underflow
        wr(0, 32'd0);
        @(negedge clk);
        chk("R1", "hsync", int'(lcd_hsync), 0);
        chk("R1", "vsync", int'(lcd_vsync), 1);
        chk("R1", "de", int'(lcd_de), 0);
        chk("R1", "rgb", int'(lcd_rgb), 0);
        chk("R1", "pix_ready", int'(pix_ready), 0);
        scenario(0, 0, 0, 0, 0, F + 2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule